// File: doc/BRIEF.md
# Scrambler LFSR and HEC Register

This block gives a host processor two small registers that support cell-based transmission-convergence work. The first is a 31-bit linear feedback shift register used for payload scrambling. The host seeds it through a 32-bit write port. It advances one position each time the host pulses a step strobe. The host reads it back through a 32-bit port whose top bit is computed, not stored: it is the feedback value that the next step will shift in.

The second is an 8-bit header-error-check register. The host can load it directly. It can also present one byte per strobe, and each byte is folded into the register with a CRC-8 whose generator is x^8+x^2+x+1. The register contents are always visible on a read port.

Each register has a per-cycle command decode with three commands, and a load always beats an advance. The LFSR decode is `CMD_IDLE`, `CMD_LOAD` or `CMD_STEP`. `CMD_LOAD` is chosen when the write enable is high. `CMD_STEP` is chosen when only the step strobe is high. Otherwise the decode is `CMD_IDLE`. The HEC decode follows the same pattern with `HCMD_IDLE`, `HCMD_LOAD` and `HCMD_FOLD`. `HCMD_FOLD` is chosen when a byte is presented and no load is requested. The two decodes run side by side and never affect each other.

Top module: `scr_lfsr_hec`

## Requirements
- R1: While reset is asserted (rst_n low), and after it is released, the LFSR readback is 0 and the HEC readback is 0 until the host issues a command.
- R2: LFSR readback bits 30..0 equal the stored 31-bit state, and readback bit 31 equals state bit 30 XOR state bit 27.
- R3: In a cycle with neither lfsr_wr_en nor lfsr_step high, the LFSR state is unchanged.
- R4: A cycle with lfsr_step high and lfsr_wr_en low shifts the state left by one position. State bit 30 is discarded, and the old readback bit 31 enters at state bit 0.
- R5: A cycle with lfsr_wr_en high loads lfsr_wr_data bits 30..0 into the state. lfsr_wr_data bit 31 has no effect.
- R6: When lfsr_wr_en and lfsr_step are both high in one cycle, the write is performed and no step occurs.
- R7: A cycle with hec_wr_en high loads hec_wr_data into the HEC register.
- R8: A cycle with hec_byte_vld high and hec_wr_en low folds hec_byte into the HEC register. The byte is XORed into the register, then eight times the register is shifted left and, if the bit shifted out was 1, XORed with 8'h07. There is no reflection and no final XOR.
- R9: When hec_wr_en and hec_byte_vld are both high in one cycle, the load is performed and the byte is not folded.
- R10: LFSR commands leave the HEC register unchanged, and HEC commands leave the LFSR state unchanged.
- R11: In a cycle with neither hec_wr_en nor hec_byte_vld high, the HEC register is unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| lfsr_wr_en | input | 1 | Seed write strobe |
| lfsr_wr_data | input | 32 | Seed value; bit 31 is ignored |
| lfsr_step | input | 1 | Advance the LFSR by one position |
| lfsr_rd_data | output | 32 | Computed feedback bit over the 31-bit state |
| hec_wr_en | input | 1 | HEC load strobe |
| hec_wr_data | input | 8 | HEC load value |
| hec_byte_vld | input | 1 | Fold hec_byte into the HEC register |
| hec_byte | input | 8 | Byte to fold |
| hec_rd_data | output | 8 | HEC register contents |

## Verification
On each register, a load and an advance can fall in the same cycle: a seed write together with a step strobe, or a HEC load together with a byte strobe. The bench drives both strobes on one falling edge with a seed that would give a visibly different result if the advance had won. After the next rising edge it compares the readback with the plain load value. It also steps and folds on the two registers at once to show that they stay independent, and it compares long runs of steps and folds against a bit-level model built from the requirements.

// File: rtl/scr_pkg.sv
package scr_pkg;

    typedef enum logic [1:0] {
        CMD_IDLE = 2'd0,
        CMD_LOAD = 2'd1,
        CMD_STEP = 2'd2
    } lfsr_cmd_e;

    typedef enum logic [1:0] {
        HCMD_IDLE = 2'd0,
        HCMD_LOAD = 2'd1,
        HCMD_FOLD = 2'd2
    } hec_cmd_e;

endpackage

// File: rtl/scr_lfsr_core.sv
module scr_lfsr_core
    import scr_pkg::*;
#(
    parameter int LFSR_W = 32,
    parameter int TAP_HI = 30,
    parameter int TAP_LO = 27
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [LFSR_W-1:0] wr_data,
    input  logic              step,
    output logic [LFSR_W-1:0] rd_data
);
    localparam int ST_W = LFSR_W - 1;

    lfsr_cmd_e       cmd;
    logic [ST_W-1:0] state_q;
    logic [ST_W-1:0] state_d;
    logic            fb;

    // Feedback is derived, never stored
    assign fb = state_q[TAP_HI] ^ state_q[TAP_LO];

    // Command decode: load beats step
    always_comb begin
        if (wr_en)
            cmd = CMD_LOAD;
        else if (step)
            cmd = CMD_STEP;
        else
            cmd = CMD_IDLE;
    end

    always_comb begin
        state_d = state_q;
        unique case (cmd)
            CMD_IDLE: state_d = state_q;
            CMD_LOAD: state_d = wr_data[ST_W-1:0];
            CMD_STEP: state_d = {state_q[ST_W-2:0], fb};
            default:  state_d = state_q;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state_q <= '0;
        else
            state_q <= state_d;
    end

    assign rd_data = {fb, state_q};

    AST_LFSR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en && !step) |=> $stable(state_q)); // R3
    AST_LFSR_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (state_q == $past(wr_data[ST_W-1:0]))); // R5
    AST_LFSR_SHIFT: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !wr_en) |=> (state_q[ST_W-1:1] == $past(state_q[ST_W-2:0]))); // R4
    AST_LFSR_FEED: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !wr_en) |=> (state_q[0] == $past(rd_data[LFSR_W-1]))); // R4

endmodule

// File: rtl/scr_crc8_fold.sv
module scr_crc8_fold #(
    parameter int          CRC_W = 8,
    parameter logic [CRC_W-1:0] POLY = 8'h07
) (
    input  logic [CRC_W-1:0] crc_in,
    input  logic [CRC_W-1:0] data_in,
    output logic [CRC_W-1:0] crc_out
);
    localparam int STAGES = CRC_W;

    logic [CRC_W-1:0] chain [STAGES+1];

    assign chain[0] = crc_in ^ data_in;

    // One shift-and-reduce stage per data bit
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
        always_comb begin
            if (chain[i][CRC_W-1])
                chain[i+1] = {chain[i][CRC_W-2:0], 1'b0} ^ POLY;
            else
                chain[i+1] = {chain[i][CRC_W-2:0], 1'b0};
        end
    end

    assign crc_out = chain[STAGES];

endmodule

// File: rtl/scr_hec_reg.sv
module scr_hec_reg
    import scr_pkg::*;
#(
    parameter int               HEC_W    = 8,
    parameter logic [HEC_W-1:0] HEC_POLY = 8'h07
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [HEC_W-1:0] wr_data,
    input  logic             byte_vld,
    input  logic [HEC_W-1:0] byte_in,
    output logic [HEC_W-1:0] rd_data
);
    hec_cmd_e         cmd;
    logic [HEC_W-1:0] hec_q;
    logic [HEC_W-1:0] hec_d;
    logic [HEC_W-1:0] folded;

    scr_crc8_fold #(
        .CRC_W (HEC_W),
        .POLY  (HEC_POLY)
    ) u_fold (
        .crc_in  (hec_q),
        .data_in (byte_in),
        .crc_out (folded)
    );

    always_comb begin
        if (wr_en)
            cmd = HCMD_LOAD;
        else if (byte_vld)
            cmd = HCMD_FOLD;
        else
            cmd = HCMD_IDLE;
    end

    always_comb begin
        hec_d = hec_q;
        unique case (cmd)
            HCMD_IDLE: hec_d = hec_q;
            HCMD_LOAD: hec_d = wr_data;
            HCMD_FOLD: hec_d = folded;
            default:   hec_d = hec_q;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            hec_q <= '0;
        else
            hec_q <= hec_d;
    end

    assign rd_data = hec_q;

    AST_HEC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en && !byte_vld) |=> $stable(hec_q)); // R11
    AST_HEC_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (hec_q == $past(wr_data))); // R7
    AST_HEC_FOLD_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_vld && !wr_en && (hec_q != byte_in)) |=> (hec_q != 8'h00)); // R8

endmodule

// File: rtl/scr_lfsr_hec.sv
module scr_lfsr_hec
    import scr_pkg::*;
#(
    parameter int          LFSR_W   = 32,
    parameter int          TAP_HI   = 30,
    parameter int          TAP_LO   = 27,
    parameter int          HEC_W    = 8,
    parameter logic [7:0]  HEC_POLY = 8'h07
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              lfsr_wr_en,
    input  logic [LFSR_W-1:0] lfsr_wr_data,
    input  logic              lfsr_step,
    output logic [LFSR_W-1:0] lfsr_rd_data,
    input  logic              hec_wr_en,
    input  logic [HEC_W-1:0]  hec_wr_data,
    input  logic              hec_byte_vld,
    input  logic [HEC_W-1:0]  hec_byte,
    output logic [HEC_W-1:0]  hec_rd_data
);
    localparam logic [HEC_W-1:0] POLY_W = HEC_W'(HEC_POLY);

    scr_lfsr_core #(
        .LFSR_W (LFSR_W),
        .TAP_HI (TAP_HI),
        .TAP_LO (TAP_LO)
    ) u_lfsr (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (lfsr_wr_en),
        .wr_data (lfsr_wr_data),
        .step    (lfsr_step),
        .rd_data (lfsr_rd_data)
    );

    scr_hec_reg #(
        .HEC_W    (HEC_W),
        .HEC_POLY (POLY_W)
    ) u_hec (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (hec_wr_en),
        .wr_data  (hec_wr_data),
        .byte_vld (hec_byte_vld),
        .byte_in  (hec_byte),
        .rd_data  (hec_rd_data)
    );

    AST_STEP_CARRY: assert property (@(posedge clk) disable iff (!rst_n)
        (lfsr_step && !lfsr_wr_en) |=> (lfsr_rd_data[0] == $past(lfsr_rd_data[LFSR_W-1]))); // R2
    AST_LFSR_ISOLATED: assert property (@(posedge clk) disable iff (!rst_n)
        (!lfsr_wr_en && !lfsr_step) |=> $stable(lfsr_rd_data)); // R10
    AST_HEC_ISOLATED: assert property (@(posedge clk) disable iff (!rst_n)
        (!hec_wr_en && !hec_byte_vld) |=> $stable(hec_rd_data)); // R10
    AST_RESET_CLEAR: assert property (@(posedge clk)
        !rst_n |=> (lfsr_rd_data == '0 || !rst_n)); // R1

endmodule

// File: tb/scr_lfsr_hec_test.sv
`timescale 1ns/1ps
module scr_lfsr_hec_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        lfsr_wr_en = 1'b0;
    logic [31:0] lfsr_wr_data = '0;
    logic        lfsr_step = 1'b0;
    logic [31:0] lfsr_rd_data;
    logic        hec_wr_en = 1'b0;
    logic [7:0]  hec_wr_data = '0;
    logic        hec_byte_vld = 1'b0;
    logic [7:0]  hec_byte = '0;
    logic [7:0]  hec_rd_data;

    int tests = 0;
    int fails = 0;
    logic [30:0] m_st = '0;
    logic [7:0]  m_hec = '0;

    always #10 clk = ~clk;

    scr_lfsr_hec uut (
        .clk(clk), .rst_n(rst_n),
        .lfsr_wr_en(lfsr_wr_en), .lfsr_wr_data(lfsr_wr_data),
        .lfsr_step(lfsr_step), .lfsr_rd_data(lfsr_rd_data),
        .hec_wr_en(hec_wr_en), .hec_wr_data(hec_wr_data),
        .hec_byte_vld(hec_byte_vld), .hec_byte(hec_byte),
        .hec_rd_data(hec_rd_data)
    );

    // Vector: {lfsr_wr, step, hec_wr, byte_vld, data32, byte8}
    localparam int NV = 12;
    localparam logic [43:0] VEC [NV] = '{
        {4'b1000, 32'hFFFF_FFFF, 8'h00}, // R5 bit31 ignored, R2 fb 0
        {4'b1000, 32'h4000_0000, 8'h00}, // R2 fb 1
        {4'b0100, 32'h0000_0000, 8'h00}, // R4
        {4'b1000, 32'h0800_0001, 8'h00}, // R2 bit27 only
        {4'b0100, 32'h0000_0000, 8'h00}, // R4
        {4'b0000, 32'hDEAD_BEEF, 8'h5A}, // R3 R11
        {4'b0010, 32'h0000_00A5, 8'h00}, // R7
        {4'b0001, 32'h0000_0000, 8'h01}, // R8
        {4'b0001, 32'h0000_0000, 8'hC3}, // R8
        {4'b0101, 32'h0000_0000, 8'h80}, // R10 both advance
        {4'b1010, 32'h1234_5678, 8'h00}, // R10 both load
        {4'b0001, 32'h0000_0000, 8'hFF}  // R8
    };

    function automatic logic [30:0] m_step(input logic [30:0] s);
        return {s[29:0], s[30] ^ s[27]};
    endfunction

    function automatic logic [7:0] m_fold(input logic [7:0] c, input logic [7:0] b);
        logic [7:0] r;
        r = c ^ b;
        for (int i = 0; i < 8; i++)
            r = r[7] ? ((r << 1) ^ 8'h07) : (r << 1);
        return r;
    endfunction

    function automatic logic [31:0] m_rd(input logic [30:0] s);
        return {s[30] ^ s[27], s};
    endfunction

    task automatic chk32(input string tag, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic apply(input logic lw, input logic st, input logic hw, input logic hv,
                         input logic [31:0] d, input logic [7:0] b);
        @(negedge clk);
        lfsr_wr_en = lw; lfsr_step = st; lfsr_wr_data = d;
        hec_wr_en = hw; hec_byte_vld = hv; hec_wr_data = d[7:0]; hec_byte = b;
        @(negedge clk);
        lfsr_wr_en = 0; lfsr_step = 0; hec_wr_en = 0; hec_byte_vld = 0;
        if (lw) m_st = d[30:0];
        else if (st) m_st = m_step(m_st);
        if (hw) m_hec = d[7:0];
        else if (hv) m_hec = m_fold(m_hec, b);
    endtask

    task automatic chk_both(input string tag);
        chk32({tag, " lfsr"}, lfsr_rd_data, m_rd(m_st));
        chk32({tag, " hec"}, {24'h0, hec_rd_data}, {24'h0, m_hec});
    endtask

    initial begin
        #(20 * 200000);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        // R1: values during and after reset
        repeat (3) @(negedge clk);
        chk32("R1 in reset lfsr", lfsr_rd_data, 32'h0);
        chk32("R1 in reset hec", {24'h0, hec_rd_data}, 32'h0);
        rst_n = 1'b1;
        @(negedge clk);
        chk_both("R1 after reset");

        for (int v = 0; v < NV; v++) begin
            apply(VEC[v][43], VEC[v][42], VEC[v][41], VEC[v][40],
                  VEC[v][39:8], VEC[v][7:0]);
            chk_both("R2 R4 R5 R7 R8 table");
        end

        // Known values from the requirements
        apply(1, 0, 0, 0, 32'hFFFF_FFFF, 8'h00);
        chk32("R5 bit31 dropped", lfsr_rd_data, 32'h7FFF_FFFF);
        apply(1, 0, 0, 0, 32'h4000_0000, 8'h00);
        chk32("R2 computed top bit", lfsr_rd_data, 32'hC000_0000);
        apply(0, 1, 0, 0, 32'h0, 8'h00);
        chk32("R4 feedback enters bit0", lfsr_rd_data, 32'h0000_0001);
        apply(0, 0, 1, 0, 32'h0000_0000, 8'h00);
        apply(0, 0, 0, 1, 32'h0, 8'h01);
        chk32("R8 single byte", {24'h0, hec_rd_data}, 32'h07);

        // R6: write and step together, seed chosen so a step would differ
        apply(1, 1, 0, 0, 32'h4800_0003, 8'h00);
        chk32("R6 write wins", lfsr_rd_data, 32'h4800_0003);
        // R9: load and byte together
        apply(0, 0, 1, 1, 32'h0000_003C, 8'h99);
        chk32("R9 load wins", {24'h0, hec_rd_data}, 32'h3C);

        // R3 R11: idle cycles
        repeat (4) @(negedge clk);
        chk_both("R3 R11 idle hold");

        // R10: step only, HEC must hold; fold only, LFSR must hold
        apply(0, 1, 0, 0, 32'h0, 8'h00);
        chk32("R10 hec untouched by step", {24'h0, hec_rd_data}, 32'h3C);
        apply(0, 0, 0, 1, 32'h0, 8'h77);
        chk32("R10 lfsr untouched by fold", lfsr_rd_data, m_rd(m_st));

        // R4 R8: long runs against the model
        apply(1, 0, 0, 0, 32'h1ACE_F00D, 8'h00);
        for (int k = 0; k < 200; k++) begin
            apply(0, 1, 0, 1, 32'h0, 8'(k * 37 + 11));
            chk_both("R4 R8 long run");
        end

        // R1: reset during operation
        @(negedge clk);
        rst_n = 1'b0;
        m_st = '0; m_hec = '0;
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk_both("R1 re-reset");

        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule